// File: doc/BRIEF.md
# SMBus Host Register and Status Unit

This block is the register front end of an SMBus host controller. Software reaches it through a byte-wide read/write register port. It holds the control byte, the command byte, the target address, two data bytes, a block data port, a receive-slave address and a status byte. The status flags are cleared by writing ones. The block passes settings to a separate protocol engine and takes back that engine's completion, error and per-byte strobes. Bus sequencing and SCL/SDA timing live in the engine, not here.

A transaction is launched by writing the start bit of the control byte. The unit then raises the busy flag and gives the engine a one-cycle start pulse. When the engine reports success, a device error or a bus error, busy drops and the matching flag is latched. During block transfers the engine reports every finished byte. The unit raises a byte-done flag and holds the engine with a stall output until software clears that flag. Software can tell the engine that the next byte is the final one through a last-byte control bit. It can abort a running transaction with a kill bit. An interrupt output summarises the completion flags, gated by an enable bit.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register reads 0x00, and irq, eng_start, eng_kill, eng_hold and eng_last are all 0.
- R2: Software writes to offsets 0x3 (command), 0x4 (target address), 0x5 (data 0), 0x6 (data 1), 0x7 (block data) and 0x9 (receive-slave address) read back unchanged. Offsets 0x1, 0x8 and 0xA-0xF read 0x00, and writes to them change no register.
- R3: The control byte at offset 0x2 reads back bit 0 (interrupt enable), bits 4:2 (transaction type), bit 5 (last byte) and bit 7 (PEC enable) as written. Bit 6 (start) and bit 1 (kill) always read 0. The type and PEC fields appear on eng_type and eng_pec.
- R4: Writing control with bit 6 set while status bit 0 (busy) is 0 sets busy and drives eng_start high for exactly one cycle, starting the cycle after the write.
- R5: A control write with bit 6 set while busy is 1 produces no eng_start pulse and leaves status unchanged.
- R6: An eng_done, eng_dev_err or eng_bus_err strobe clears busy and sets status bit 1, bit 2 or bit 3 respectively.
- R7: Status bits 1-7 clear when 1 is written to them, and writing 0 leaves them unchanged. Writing back a value just read clears every pending flag. Busy (bit 0) ignores writes. A hardware set in the same cycle as a clear leaves the flag set.
- R8: An eng_byte strobe sets status bit 7 (byte done). eng_hold equals that flag and stays high until software writes 1 to bit 7.
- R9: An eng_load strobe writes eng_ldata into data 0, data 1 or block data when eng_lsel is 0, 1 or 2. It wins over a software write to the same register in the same cycle.
- R10: eng_last follows control bit 5.
- R11: Writing control with bit 1 set drives eng_kill high for one cycle, clears busy and sets status bit 4 (failed). A kill in the same write as start suppresses the start.
- R12: irq is 1 exactly when control bit 0 is 1 and any of status bits 1-4 is set. Bits 5-7 never raise irq.
- R13: A high alert_in sets status bit 5. A status read that returns bit 6 (in use) as 0 sets it, so the next read returns 1. Writing 1 to bit 6 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect on status only) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| eng_start | output | 1 | One-cycle start pulse to engine |
| eng_kill | output | 1 | One-cycle abort pulse to engine |
| eng_type | output | 3 | Transaction type |
| eng_pec | output | 1 | PEC enable |
| eng_last | output | 1 | Next byte is the final one |
| eng_hold | output | 1 | Engine must wait (byte done pending) |
| eng_cmd | output | 8 | Command byte |
| eng_taddr | output | 8 | Target address byte |
| eng_data0 | output | 8 | Data 0 byte |
| eng_data1 | output | 8 | Data 1 byte |
| eng_blk | output | 8 | Block data byte |
| eng_slv | output | 8 | Receive-slave address |
| eng_done | input | 1 | Successful completion strobe |
| eng_dev_err | input | 1 | Device error strobe |
| eng_bus_err | input | 1 | Bus error strobe |
| eng_byte | input | 1 | Block byte finished strobe |
| eng_load | input | 1 | Engine writes a received byte |
| eng_lsel | input | 2 | Target of eng_load: 0 data 0, 1 data 1, 2 block |
| eng_ldata | input | 8 | Received byte |
| alert_in | input | 1 | Alert level from the bus |
| irq | output | 1 | Interrupt request |

## Verification
A busy flag stuck high or dropped early shows up within one cycle as a missing or extra eng_start pulse and as a wrong bit 0 in the next status read. A lost byte-done flag releases eng_hold at once, before any software write, so the engine would run ahead by one byte. A flag that fails to clear, or clears when it should not, shows in the status value and in irq on the cycle after the write. The in-use semaphore shows a wrong value on the very next read.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

  localparam int BYTE_W = 8;

  // register offsets
  localparam int OFS_STAT  = 'h0;
  localparam int OFS_CTRL  = 'h2;
  localparam int OFS_CMD   = 'h3;
  localparam int OFS_TADDR = 'h4;
  localparam int OFS_D0    = 'h5;
  localparam int OFS_D1    = 'h6;
  localparam int OFS_BLK   = 'h7;
  localparam int OFS_SLV   = 'h9;

  // status bit positions
  localparam int ST_BUSY  = 0;
  localparam int ST_OK    = 1;
  localparam int ST_DEV   = 2;
  localparam int ST_BUS   = 3;
  localparam int ST_FAIL  = 4;
  localparam int ST_ALERT = 5;
  localparam int ST_INUSE = 6;
  localparam int ST_BYTE  = 7;

  // control bit positions
  localparam int CT_IE    = 0;
  localparam int CT_KILL  = 1;
  localparam int CT_TLO   = 2;
  localparam int CT_LAST  = 5;
  localparam int CT_START = 6;
  localparam int CT_PEC   = 7;

  // data byte register set
  localparam int NUM_DREG = 6;
  typedef enum logic [2:0] {
    DR_CMD   = 3'd0,
    DR_TADDR = 3'd1,
    DR_D0    = 3'd2,
    DR_D1    = 3'd3,
    DR_BLK   = 3'd4,
    DR_SLV   = 3'd5
  } dreg_e;

  typedef enum logic [1:0] {
    LD_D0  = 2'd0,
    LD_D1  = 2'd1,
    LD_BLK = 2'd2,
    LD_NONE = 2'd3
  } ld_sel_e;

  typedef struct packed {
    logic       pec;
    logic       last;
    logic [2:0] ttype;
    logic       ie;
  } ctrl_t;

  function automatic int dreg_offset(input int idx);
    case (idx)
      0: dreg_offset = OFS_CMD;
      1: dreg_offset = OFS_TADDR;
      2: dreg_offset = OFS_D0;
      3: dreg_offset = OFS_D1;
      4: dreg_offset = OFS_BLK;
      default: dreg_offset = OFS_SLV;
    endcase
  endfunction

  // which load select (if any) targets a data register
  function automatic int dreg_load_sel(input int idx);
    case (idx)
      2: dreg_load_sel = 0;
      3: dreg_load_sel = 1;
      4: dreg_load_sel = 2;
      default: dreg_load_sel = -1;
    endcase
  endfunction

endpackage

// File: rtl/smb_ctrl_reg.sv
module smb_ctrl_reg
  import smb_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              busy,
  output ctrl_t             ctrl,
  output logic              start_ok,
  output logic              kill_ok,
  output logic              start_pulse,
  output logic              kill_pulse
);

  ctrl_t ctrl_q, ctrl_d;
  logic  start_q, start_d;
  logic  kill_q, kill_d;

  // kill wins over a start carried in the same write
  assign kill_ok  = wr_en & wdata[CT_KILL];
  assign start_ok = wr_en & wdata[CT_START] & ~busy & ~wdata[CT_KILL];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.ie    = wdata[CT_IE];
      ctrl_d.ttype = wdata[CT_TLO+2:CT_TLO];
      ctrl_d.last  = wdata[CT_LAST];
      ctrl_d.pec   = wdata[CT_PEC];
    end
    start_d = start_ok;
    kill_d  = kill_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      start_q <= 1'b0;
      kill_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      start_q <= start_d;
      kill_q  <= kill_d;
    end
  end

  assign ctrl        = ctrl_q;
  assign start_pulse = start_q;
  assign kill_pulse  = kill_q;

endmodule

// File: rtl/smb_status_flags.sv
module smb_status_flags
  import smb_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic              sw_rd,
  input  logic [BYTE_W-1:0] sw_wdata,
  input  logic              start_ok,
  input  logic              kill_ok,
  input  logic              eng_done,
  input  logic              eng_dev_err,
  input  logic              eng_bus_err,
  input  logic              eng_byte,
  input  logic              alert_in,
  output logic [BYTE_W-1:0] status
);

  logic [BYTE_W-1:0] flag_q, flag_d;
  logic [BYTE_W-1:0] set_vec;
  logic              term;

  assign term = kill_ok | eng_done | eng_dev_err | eng_bus_err;

  always_comb begin
    set_vec           = '0;
    set_vec[ST_OK]    = eng_done;
    set_vec[ST_DEV]   = eng_dev_err;
    set_vec[ST_BUS]   = eng_bus_err;
    set_vec[ST_FAIL]  = kill_ok;
    set_vec[ST_ALERT] = alert_in;
    set_vec[ST_INUSE] = sw_rd & ~flag_q[ST_INUSE];
    set_vec[ST_BYTE]  = eng_byte;
  end

  // busy: start has priority over a terminating strobe
  always_comb begin
    if (start_ok)
      flag_d[ST_BUSY] = 1'b1;
    else if (term)
      flag_d[ST_BUSY] = 1'b0;
    else
      flag_d[ST_BUSY] = flag_q[ST_BUSY];
  end

  // write-one-to-clear flags, hardware set wins
  for (genvar i = 1; i < BYTE_W; i++) begin : g_w1c
    always_comb begin
      flag_d[i] = set_vec[i] | (flag_q[i] & ~(sw_wr & sw_wdata[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= '0;
    else
      flag_q <= flag_d;
  end

  assign status = flag_q;

endmodule

// File: rtl/smb_data_regs.sv
module smb_data_regs
  import smb_host_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [BYTE_W-1:0] sw_wdata,
  input  logic              ld_en,
  input  logic [1:0]        ld_sel,
  input  logic [BYTE_W-1:0] ld_data,
  output logic [BYTE_W-1:0] dreg [NUM_DREG]
);

  logic [BYTE_W-1:0] q [NUM_DREG];
  logic [BYTE_W-1:0] d [NUM_DREG];

  for (genvar i = 0; i < NUM_DREG; i++) begin : g_reg
    localparam int OFS = dreg_offset(i);
    localparam int LDS = dreg_load_sel(i);
    logic sw_hit;
    logic ld_hit;

    assign sw_hit = sw_wr && (sw_addr == ADDR_W'(OFS));

    if (LDS >= 0) begin : g_ld
      assign ld_hit = ld_en && (ld_sel == 2'(LDS));
    end else begin : g_nold
      assign ld_hit = 1'b0;
    end

    // engine load wins over software
    always_comb begin
      if (ld_hit)
        d[i] = ld_data;
      else if (sw_hit)
        d[i] = sw_wdata;
      else
        d[i] = q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[i] <= '0;
      else
        q[i] <= d[i];
    end

    assign dreg[i] = q[i];
  end

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              eng_start,
  output logic              eng_kill,
  output logic [2:0]        eng_type,
  output logic              eng_pec,
  output logic              eng_last,
  output logic              eng_hold,
  output logic [7:0]        eng_cmd,
  output logic [7:0]        eng_taddr,
  output logic [7:0]        eng_data0,
  output logic [7:0]        eng_data1,
  output logic [7:0]        eng_blk,
  output logic [7:0]        eng_slv,
  input  logic              eng_done,
  input  logic              eng_dev_err,
  input  logic              eng_bus_err,
  input  logic              eng_byte,
  input  logic              eng_load,
  input  logic [1:0]        eng_lsel,
  input  logic [7:0]        eng_ldata,
  input  logic              alert_in,
  output logic              irq
);

  logic              hit_stat, hit_ctrl;
  logic              start_ok, kill_ok;
  logic [BYTE_W-1:0] status_q;
  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] dreg [NUM_DREG];
  logic [BYTE_W-1:0] ctrl_rd;

  assign hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
  assign hit_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));

  smb_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_wr & hit_ctrl),
    .wdata       (reg_wdata),
    .busy        (status_q[ST_BUSY]),
    .ctrl        (ctrl_q),
    .start_ok    (start_ok),
    .kill_ok     (kill_ok),
    .start_pulse (eng_start),
    .kill_pulse  (eng_kill)
  );

  smb_status_flags u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_wr       (reg_wr & hit_stat),
    .sw_rd       (reg_rd & hit_stat),
    .sw_wdata    (reg_wdata),
    .start_ok    (start_ok),
    .kill_ok     (kill_ok),
    .eng_done    (eng_done),
    .eng_dev_err (eng_dev_err),
    .eng_bus_err (eng_bus_err),
    .eng_byte    (eng_byte),
    .alert_in    (alert_in),
    .status      (status_q)
  );

  smb_data_regs #(.ADDR_W(ADDR_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_wr    (reg_wr),
    .sw_addr  (reg_addr),
    .sw_wdata (reg_wdata),
    .ld_en    (eng_load),
    .ld_sel   (eng_lsel),
    .ld_data  (eng_ldata),
    .dreg     (dreg)
  );

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[CT_IE]      = ctrl_q.ie;
    ctrl_rd[CT_TLO+2:CT_TLO] = ctrl_q.ttype;
    ctrl_rd[CT_LAST]    = ctrl_q.last;
    ctrl_rd[CT_PEC]     = ctrl_q.pec;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_STAT):  reg_rdata = status_q;
      ADDR_W'(OFS_CTRL):  reg_rdata = ctrl_rd;
      ADDR_W'(OFS_CMD):   reg_rdata = dreg[DR_CMD];
      ADDR_W'(OFS_TADDR): reg_rdata = dreg[DR_TADDR];
      ADDR_W'(OFS_D0):    reg_rdata = dreg[DR_D0];
      ADDR_W'(OFS_D1):    reg_rdata = dreg[DR_D1];
      ADDR_W'(OFS_BLK):   reg_rdata = dreg[DR_BLK];
      ADDR_W'(OFS_SLV):   reg_rdata = dreg[DR_SLV];
      default:            reg_rdata = '0;
    endcase
  end

  assign eng_type  = ctrl_q.ttype;
  assign eng_pec   = ctrl_q.pec;
  assign eng_last  = ctrl_q.last;
  assign eng_hold  = status_q[ST_BYTE];
  assign eng_cmd   = dreg[DR_CMD];
  assign eng_taddr = dreg[DR_TADDR];
  assign eng_data0 = dreg[DR_D0];
  assign eng_data1 = dreg[DR_D1];
  assign eng_blk   = dreg[DR_BLK];
  assign eng_slv   = dreg[DR_SLV];

  assign irq = ctrl_q.ie & (|status_q[ST_FAIL:ST_OK]);

endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              eng_start,
  input logic              eng_kill,
  input logic              eng_hold,
  input logic              irq,
  input logic [7:0]        status
);

  logic clr_byte;
  assign clr_byte = reg_wr && (reg_addr == '0) && reg_wdata[7];

  p_start_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> status[0]);

  p_busy_only_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> eng_start);

  p_kill_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_kill |-> (!status[0] && status[4]));

  p_hold_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_hold && !clr_byte) |=> eng_hold);

  p_irq_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status[1] || status[2] || status[3] || status[4]));

endmodule

bind smb_host_regs smb_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .eng_start (eng_start),
  .eng_kill  (eng_kill),
  .eng_hold  (eng_hold),
  .irq       (irq),
  .status    (status_q)
);

// File: tb/smb_host_regs_test.sv
module smb_host_regs_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       eng_start, eng_kill, eng_pec, eng_last, eng_hold;
  logic [2:0] eng_type;
  logic [7:0] eng_cmd, eng_taddr, eng_data0, eng_data1, eng_blk, eng_slv;
  logic       eng_done = 1'b0, eng_dev_err = 1'b0, eng_bus_err = 1'b0;
  logic       eng_byte = 1'b0, eng_load = 1'b0, alert_in = 1'b0;
  logic [1:0] eng_lsel = '0;
  logic [7:0] eng_ldata = '0;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  smb_host_regs uut (.*);

  task automatic report();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, got %0d cycles expected < 20000", cyc);
      report();
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 chk(tag, reg_rdata, exp);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // status read, then drop the in-use flag it set
  task automatic rd_st(input logic [7:0] exp, input string tag);
    rd(4'h0, exp, tag);
    wr(4'h0, 8'h40);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic load(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); eng_load = 1'b1; eng_lsel = sel; eng_ldata = d;
    @(negedge clk); eng_load = 1'b0;
  endtask

  // {write, offset, data, expected read}
  localparam int NV = 22;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 4'h3, 8'hA5, 8'h00}, {1'b0, 4'h3, 8'h00, 8'hA5},
    {1'b1, 4'h4, 8'h3C, 8'h00}, {1'b0, 4'h4, 8'h00, 8'h3C},
    {1'b1, 4'h5, 8'h11, 8'h00}, {1'b0, 4'h5, 8'h00, 8'h11},
    {1'b1, 4'h6, 8'h22, 8'h00}, {1'b0, 4'h6, 8'h00, 8'h22},
    {1'b1, 4'h7, 8'h33, 8'h00}, {1'b0, 4'h7, 8'h00, 8'h33},
    {1'b1, 4'h9, 8'h44, 8'h00}, {1'b0, 4'h9, 8'h00, 8'h44},
    {1'b1, 4'h1, 8'hFF, 8'h00}, {1'b0, 4'h1, 8'h00, 8'h00},
    {1'b1, 4'h8, 8'hFF, 8'h00}, {1'b0, 4'h8, 8'h00, 8'h00},
    {1'b1, 4'hA, 8'h55, 8'h00}, {1'b0, 4'hA, 8'h00, 8'h00},
    {1'b0, 4'h3, 8'h00, 8'hA5},
    {1'b1, 4'h2, 8'hBD, 8'h00}, {1'b0, 4'h2, 8'h00, 8'hBD},
    {1'b1, 4'h2, 8'h00, 8'h00}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 eng_start", {7'd0, eng_start}, 8'h00);
    chk("R1 eng_kill", {7'd0, eng_kill}, 8'h00);
    chk("R1 eng_hold", {7'd0, eng_hold}, 8'h00);
    chk("R1 eng_last", {7'd0, eng_last}, 8'h00);
    for (int a = 2; a < 10; a++) begin
      if (a != 8) rd(4'(a), 8'h00, "R1 reg reset");
    end
    rd_st(8'h00, "R1 status reset");

    // R13 in-use semaphore
    rd(4'h0, 8'h00, "R13 in-use first read");
    rd(4'h0, 8'h40, "R13 in-use second read");
    wr(4'h0, 8'h40);
    rd(4'h0, 8'h00, "R13 in-use cleared");
    wr(4'h0, 8'h40);

    // R2 / R3 register table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20])
        wr(VEC[i][19:16], VEC[i][15:8]);
      else
        rd(VEC[i][19:16], VEC[i][7:0],
           (VEC[i][19:16] == 4'h2) ? "R3 control readback" : "R2 offset map");
    end
    chk("R3 eng_type", {5'd0, eng_type}, 8'h00);

    // R4 start
    wr(4'h2, 8'h55);
    chk("R4 start pulse", {7'd0, eng_start}, 8'h01);
    chk("R3 eng_type", {5'd0, eng_type}, 8'h05);
    chk("R3 eng_pec", {7'd0, eng_pec}, 8'h00);
    @(negedge clk);
    chk("R4 start one cycle", {7'd0, eng_start}, 8'h00);
    rd_st(8'h01, "R4 busy set");

    // R5 start while busy ignored; R7 busy not writable
    wr(4'h2, 8'h55);
    chk("R5 no pulse while busy", {7'd0, eng_start}, 8'h00);
    rd_st(8'h01, "R5 status unchanged");
    wr(4'h0, 8'h01);
    rd_st(8'h01, "R7 busy ignores write");

    // R8 byte-done handshake
    pulse(eng_byte);
    chk("R8 hold raised", {7'd0, eng_hold}, 8'h01);
    rd_st(8'h81, "R8 byte done flag");
    repeat (3) @(negedge clk);
    wr(4'h0, 8'h00);
    chk("R8 hold after zero write", {7'd0, eng_hold}, 8'h01);
    wr(4'h0, 8'h80);
    chk("R8 hold released", {7'd0, eng_hold}, 8'h00);
    rd_st(8'h01, "R8 flag cleared");

    // R9 engine loads
    load(2'd2, 8'h9A);
    rd(4'h7, 8'h9A, "R9 block load");
    load(2'd0, 8'h12);
    rd(4'h5, 8'h12, "R9 data0 load");
    load(2'd1, 8'h34);
    rd(4'h6, 8'h34, "R9 data1 load");
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h5; reg_wdata = 8'hEE;
    eng_load = 1'b1; eng_lsel = 2'd0; eng_ldata = 8'h77;
    @(negedge clk);
    reg_wr = 1'b0; eng_load = 1'b0;
    chk("R9 engine wins", eng_data0, 8'h77);

    // R10 last byte
    wr(4'h2, 8'h20);
    chk("R10 last set", {7'd0, eng_last}, 8'h01);
    wr(4'h2, 8'h00);
    chk("R10 last clear", {7'd0, eng_last}, 8'h00);

    // R6 / R7 done with simultaneous clear: set wins
    @(negedge clk);
    eng_done = 1'b1; reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 8'h02;
    @(negedge clk);
    eng_done = 1'b0; reg_wr = 1'b0;
    rd_st(8'h02, "R6 done clears busy, R7 set wins");
    chk("R12 irq gated off", {7'd0, irq}, 8'h00);
    wr(4'h2, 8'h01);
    chk("R12 irq on", {7'd0, irq}, 8'h01);
    wr(4'h0, 8'h02);
    chk("R12 irq drops", {7'd0, irq}, 8'h00);
    rd_st(8'h00, "R7 ok cleared");

    // R6 device error
    wr(4'h2, 8'h41);
    pulse(eng_dev_err);
    rd_st(8'h04, "R6 device error");
    chk("R12 irq dev", {7'd0, irq}, 8'h01);
    wr(4'h0, 8'h04);
    rd_st(8'h00, "R7 dev cleared");

    // R6 bus error
    wr(4'h2, 8'h41);
    pulse(eng_bus_err);
    rd_st(8'h08, "R6 bus error");
    wr(4'h0, 8'hFF);
    rd_st(8'h00, "R7 all-ones clear");

    // R11 kill
    wr(4'h2, 8'h41);
    wr(4'h2, 8'h03);
    chk("R11 kill pulse", {7'd0, eng_kill}, 8'h01);
    rd_st(8'h10, "R11 failed, not busy");
    chk("R12 irq failed", {7'd0, irq}, 8'h01);
    wr(4'h0, 8'h10);
    wr(4'h2, 8'h43);
    chk("R11 kill beats start", {7'd0, eng_start}, 8'h00);
    rd_st(8'h10, "R11 no busy on kill+start");
    wr(4'h0, 8'h10);

    // R13 alert, not an irq cause
    pulse(alert_in);
    rd_st(8'h20, "R13 alert flag");
    chk("R12 alert no irq", {7'd0, irq}, 8'h00);
    wr(4'h0, 8'h20);
    rd_st(8'h00, "R13 alert cleared");

    // R7 write back read value
    pulse(alert_in);
    pulse(eng_byte);
    pulse(eng_dev_err);
    rd(4'h0, 8'hA4, "R7 pending mix");
    rd(4'h0, 8'hE4, "R13 in-use with mix");
    wr(4'h0, 8'hE4);
    rd(4'h0, 8'h00, "R7 write-back clears all");
    wr(4'h0, 8'h40);

    report();
  end

endmodule